// File: doc/BRIEF.md
# Zero-Crossing Phase Detector and Loop Filter

This block closes the phase loop of a table-driven sine generator. An external mains-frequency reference, already squared up, enters asynchronously; the block brings it into the clock domain, picks either its rising or its falling transition, and at that moment samples where the generator currently is in its output cycle. The generator reports a step index within the current half-cycle and a flag telling which half-cycle it is in; the block turns these into a signed position centred on the expected crossing.

From that position, less a programmable phase offset that moves the lock point, it forms a phase error and the change of that error since the last accepted reference edge. A proportional-plus-derivative law with power-of-two weights and no integral term turns the two into a signed trim value, which a downstream accumulator adds to its period count. A lock flag reports that both error and trim are small. All arithmetic is signed 16-bit with clamping, so a large offset or a wild reference cannot wrap the result.

Top module: `zc_phase_filter`

## Requirements
- R1: The reference input passes two synchroniser flops and an edge detector; `trim_valid` is high for exactly one clock, three rising clock edges after the selected transition of `ref_in` is first sampled, and results are produced for no other reason.
- R2: `edge_sel` = 1 selects rising transitions of `ref_in`, `edge_sel` = 0 selects falling ones; a transition of the other polarity produces no pulse and changes no output.
- R3: The captured position is `step_idx` + (200 when `second_half` = 1, else 0) − 200, with HALF_STEPS = 200 and `step_idx` in 0..199.
- R4: `phase_err` equals the captured position minus the signed `phase_ofs`.
- R5: `trim` equals 8 × (e/2 + 8 × (e − p)), where e is the new error, p the error of the previous accepted edge, and e/2 truncates toward zero.
- R6: The previous-error term is updated only on accepted edges and is zero after reset, so the first edge after reset uses p = 0.
- R7: Error, error change and trim each clamp to the range −32768..32767 instead of wrapping.
- R8: `locked` is set on an accepted edge when |phase_err| < 3 and |trim| < 80, cleared on an accepted edge otherwise.
- R9: While `rst_n` is low, `trim_valid`, `trim`, `phase_err` and `locked` are all zero.
- R10: Between accepted edges `trim`, `phase_err` and `locked` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Asynchronous squared reference |
| edge_sel | input | 1 | 1 = rising edge, 0 = falling edge |
| step_idx | input | 8 | Generator step within half-cycle |
| second_half | input | 1 | Generator is in second half-cycle |
| phase_ofs | input | 16 | Signed offset subtracted from position |
| trim_valid | output | 1 | One-clock pulse with new results |
| trim | output | 16 | Signed frequency-correction increment |
| phase_err | output | 16 | Signed phase error of last edge |
| locked | output | 1 | Lock indicator |

## Verification
A stale or uncleared previous-error register does not show in `phase_err` but does show in `trim` at the very next accepted edge, since the derivative term carries 64 times its weight; the bench therefore chains edges so each result depends on the one before. A wrong synchroniser depth or edge polarity moves or multiplies the `trim_valid` pulse, which the scoreboard catches by the cycle number of each pulse. Clamping errors appear only with extreme offsets, so dedicated edges drive the error and trim to both rails.

// File: rtl/zcpd_pkg.sv
package zcpd_pkg;
    localparam int DW = 16;
    typedef logic signed [DW-1:0] word_t;

    localparam logic signed [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};

    function automatic word_t clamp28(input logic signed [27:0] v);
        if (v > 28'(WMAX))      return WMAX;
        else if (v < 28'(WMIN)) return WMIN;
        else                    return v[DW-1:0];
    endfunction
endpackage

// File: rtl/zcpd_edge.sv
module zcpd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic edge_sel,
    output logic hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = ref_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (edge_sel) hit = st_q.s2 & ~st_q.s3;
        else          hit = ~st_q.s2 & st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/zcpd_position.sv
module zcpd_position #(
    parameter int HALF_STEPS = 200,
    localparam int IW = $clog2(HALF_STEPS)
) (
    input  logic [IW-1:0]         step_idx,
    input  logic                  second_half,
    input  logic signed [15:0]    phase_ofs,
    output logic signed [15:0]    err
);
    logic signed [27:0] pos;
    logic signed [27:0] diff;

    always_comb begin
        pos  = 28'(signed'({1'b0, step_idx}))
             + (second_half ? 28'(HALF_STEPS) : 28'sd0)
             - 28'(HALF_STEPS);
        diff = pos - 28'(phase_ofs);
        err  = zcpd_pkg::clamp28(diff);
    end
endmodule

// File: rtl/zcpd_law.sv
module zcpd_law (
    input  logic signed [15:0] err,
    input  logic signed [15:0] prev_err,
    output logic signed [15:0] trim,
    output logic               lock_ok
);
    localparam int LOCK_ERR  = 3;
    localparam int LOCK_TRIM = 80;

    logic signed [15:0] delta;
    logic signed [15:0] half;
    logic signed [27:0] wide;

    always_comb begin
        delta   = zcpd_pkg::clamp28(28'(err) - 28'(prev_err));
        half    = err / 16'sd2;
        wide    = (28'(half) + (28'(delta) <<< 3)) <<< 3;
        trim    = zcpd_pkg::clamp28(wide);
        lock_ok = (err  < 16'(LOCK_ERR))  && (err  > -16'(LOCK_ERR)) &&
                  (trim < 16'(LOCK_TRIM)) && (trim > -16'(LOCK_TRIM));
    end
endmodule

// File: rtl/zc_phase_filter.sv
module zc_phase_filter #(
    parameter int HALF_STEPS = 200,
    localparam int IW = $clog2(HALF_STEPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_in,
    input  logic                 edge_sel,
    input  logic [IW-1:0]        step_idx,
    input  logic                 second_half,
    input  logic signed [15:0]   phase_ofs,
    output logic                 trim_valid,
    output logic signed [15:0]   trim,
    output logic signed [15:0]   phase_err,
    output logic                 locked
);
    typedef struct packed {
        logic                vld;
        logic signed [15:0]  trim;
        logic signed [15:0]  err;
        logic signed [15:0]  prev;
        logic                lock;
    } state_t;

    state_t st_d, st_q;
    logic hit;
    logic signed [15:0] new_err, new_trim;
    logic new_lock;

    zcpd_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .edge_sel(edge_sel), .hit(hit)
    );

    zcpd_position #(.HALF_STEPS(HALF_STEPS)) u_pos (
        .step_idx(step_idx), .second_half(second_half),
        .phase_ofs(phase_ofs), .err(new_err)
    );

    zcpd_law u_law (
        .err(new_err), .prev_err(st_q.prev),
        .trim(new_trim), .lock_ok(new_lock)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = hit;
        if (hit) begin
            st_d.err  = new_err;
            st_d.prev = new_err;
            st_d.trim = new_trim;
            st_d.lock = new_lock;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trim_valid = st_q.vld;
    assign trim       = st_q.trim;
    assign phase_err  = st_q.err;
    assign locked     = st_q.lock;
endmodule

// File: rtl/zcpd_checker.sv
module zcpd_checker (
    input logic               clk,
    input logic               rst_n,
    input logic               trim_valid,
    input logic signed [15:0] trim,
    input logic signed [15:0] phase_err,
    input logic               locked,
    input logic signed [15:0] phase_ofs
);
    // R1
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_valid |=> !trim_valid);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_valid |-> ($stable(trim) && $stable(phase_err) && $stable(locked)));

    // R8
    lock_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (phase_err < 16'sd3 && phase_err > -16'sd3 &&
                    trim < 16'sd80 && trim > -16'sd80));

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_valid && $past(phase_ofs, 1) == 16'sd0 && phase_ofs == 16'sd0)
            |-> (phase_err >= -16'sd200 && phase_err <= 16'sd199));
endmodule

bind zc_phase_filter zcpd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .trim_valid(trim_valid), .trim(trim),
    .phase_err(phase_err), .locked(locked), .phase_ofs(phase_ofs)
);

// File: tb/tb_zc_phase_filter.sv
module tb_zc_phase_filter;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, ref_in = 0, edge_sel = 1, second_half = 0;
    logic [7:0] step_idx = 0;
    logic signed [15:0] phase_ofs = 0;
    logic trim_valid, locked;
    logic signed [15:0] trim, phase_err;

    zc_phase_filter dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .edge_sel(edge_sel),
        .step_idx(step_idx), .second_half(second_half), .phase_ofs(phase_ofs),
        .trim_valid(trim_valid), .trim(trim), .phase_err(phase_err), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int cyc; int err; int trim; bit lock; string tag;
    } exp_t;
    exp_t q[$];

    int cyc = 0, n_chk = 0, n_bad = 0, prev_m = 0;
    int last_err = 0, last_trim = 0;
    bit last_lock = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // driver: one transition of ref_in towards lvl, with generator state
    task automatic drive(input bit lvl, input bit sel, input int idx,
                         input bit hf, input int ofs, input string tag);
        exp_t e;
        int pos, er, d, c;
        @(negedge clk);
        edge_sel = sel; step_idx = 8'(idx); second_half = hf;
        phase_ofs = 16'(ofs);
        ref_in = lvl;
        if (lvl == sel) begin
            pos = idx + (hf ? 200 : 0) - 200;          // R3
            er  = sat(pos - ofs);                       // R4 R7
            d   = sat(er - prev_m);                     // R6
            c   = sat(8 * (er / 2 + 8 * d));            // R5
            prev_m = er;
            e.cyc = cyc + 3; e.err = er; e.trim = c;
            e.lock = (er < 3 && er > -3 && c < 80 && c > -80);  // R8
            e.tag = tag;
            q.push_back(e);
            last_err = er; last_trim = c; last_lock = e.lock;
        end
        repeat (6) @(negedge clk);
        // R10 / R2: outputs hold at the latest expected values
        check({tag, " hold err R10"}, phase_err, last_err);
        check({tag, " hold trim R10"}, trim, last_trim);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && trim_valid) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R2 unexpected pulse: actual 1 expected 0 at cycle %0d", cyc);
                end else begin
                    e = q.pop_front();
                    check({e.tag, " cycle R1"}, cyc, e.cyc);
                    check({e.tag, " err R4"}, phase_err, e.err);
                    check({e.tag, " trim R5"}, trim, e.trim);
                    check({e.tag, " lock R8"}, locked, e.lock);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("reset valid R9", trim_valid, 0);
        check("reset trim R9", trim, 0);
        check("reset err R9", phase_err, 0);
        check("reset lock R9", locked, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);

        drive(1, 1, 10, 0, 0, "first R6");          // -190, p=0
        drive(0, 1, 5, 0, 0, "ignored fall R2");
        drive(1, 1, 199, 1, 0, "late R3");
        drive(0, 1, 0, 0, 0, "ignored fall2 R2");
        drive(1, 1, 0, 1, 0, "centre");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 0, 1, 0, "settle lock R8");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 1, 1, 0, "plus1 R8");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 2, 1, 0, "plus2 R8");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 199, 0, 0, "minus1 trunc R5");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 197, 0, 0, "minus3 R8");
        drive(0, 1, 0, 0, 0, "f");
        drive(1, 1, 5, 1, 5, "offset R4");
        // switch to falling edges
        drive(1, 0, 30, 1, 0, "ignored rise R2");
        drive(0, 0, 30, 1, 0, "fall edge R2");
        drive(1, 0, 0, 0, 0, "ignored rise2 R2");
        drive(0, 0, 120, 0, -7, "fall neg ofs R4");
        drive(1, 0, 0, 0, 0, "r");
        drive(0, 0, 150, 1, -32768, "sat high R7");
        drive(1, 0, 0, 0, 0, "r");
        drive(0, 0, 0, 0, 32767, "sat low R7");
        drive(1, 0, 0, 0, 0, "r");
        drive(0, 0, 0, 1, 0, "recover R7");

        repeat (10) @(negedge clk);
        check("queue drained R1", q.size(), 0);
        done = 1;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
    end

    initial begin
        wait (done || cyc >= 20000);
        #1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule